// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (Two-Wire Block Write)

This block is the serial control port of a clock generator. It is a two-wire (I2C) slave that owns seven 8-bit configuration registers. Each register bit drives a control line of the generator: spread-spectrum enable, amplitude and shape, a four-bit software frequency code, the choice between pin-strapped and software frequency selection, a global output tristate, and one enable per output clock (CPU, PCI, free-running PCI, AGP, SDRAM, reference). The bus lines arrive asynchronous. They pass through a synchronizer and are sampled on the block clock. The block pulls the data line low through an open-drain enable.

A write transfer has a fixed shape. The master sends the address byte, then two bytes that the block acknowledges and throws away (a command byte and a count byte). Every byte after those fills the registers in order, starting at register 0. There is no register pointer. A read transfer streams the registers from register 0 in the same order. START and STOP never change register contents. Only the power-on reset loads the defaults.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset, register 0 is 8'h00 and every implemented enable or control bit of registers 1 to 5 is 1. So at the outputs all `*_en` bits are 1, `spread_center` is 1, and the register-0 fields are 0.
- R2: The block acknowledges (drives SDA low in the ninth clock) only an address byte whose upper seven bits equal `SLAVE_ADDR` (default 7'h69). Otherwise it stays off the bus until the next START, and its registers do not change.
- R3: In a write (address LSB 0), the two bytes after the address are acknowledged, and their values change no register.
- R4: Write data bytes go to registers 0, 1, 2 and onward, in the order received. Field mapping:
  - Register 0: bit 7 `spread_wide`; bits 6:4 `freq_sel[2:0]`; bit 3 `sw_select`; bit 2 `freq_sel[3]`; bit 1 `spread_en`; bit 0 `tristate_all`.
  - Register 1: bit 7 `spread_center`; bits 3:0 `cpu_en`.
  - Register 2: bits 4:0 `pci_en`; bit 5 `agp_en[0]`; bit 6 `pci_free_en`.
  - Register 3: `sdram_en[7:0]`.
  - Register 4: bits 3:0 `sdram_en[11:8]`.
  - Register 5: bits 1:0 `ref_en`; bit 4 `agp_en[1]`.
- R5: Data bytes after the seventh register (index 6) are still acknowledged and are discarded.
- R6: In a read (address LSB 1), the block sends register bytes MSB first, starting at register 0, one per master ACK. Bits without a function, all of register 6, and indices past 6 read as 0. A master NACK ends the stream.
- R7: A STOP or a repeated START sets the next register index back to 0 and leaves the register contents unchanged.
- R8: The block changes its SDA drive only while SCL is low. Outside its acknowledge and read-data bit slots it leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| spread_wide | output | 1 | Spread amplitude select (register 0 bit 7) |
| spread_center | output | 1 | Center spread when 1, down spread when 0 |
| spread_en | output | 1 | Spread modulation enable |
| freq_sel | output | 4 | Software frequency code |
| sw_select | output | 1 | 1 = software frequency code in use |
| tristate_all | output | 1 | 1 = all clock outputs high impedance |
| cpu_en | output | 4 | CPU clock enables |
| pci_en | output | 5 | PCI clock enables |
| pci_free_en | output | 1 | Free-running PCI clock enable |
| agp_en | output | 2 | AGP clock enables |
| sdram_en | output | 12 | SDRAM clock enables |
| ref_en | output | 2 | Reference clock enables |

## Verification
The hardest cases to reach from the ports are register changes that should not happen. A write past register 6 could wrap back into register 0. A rejected address or a STOP could disturb stored data. The bench keeps its own copy of the registers and compares every output field on every clock outside the short window in which a data byte commits. A stray write therefore shows up the moment it lands. The stimulus writes nine data bytes in one transfer, then cuts a write short with a repeated START and restarts it. It also turns a write into a read mid-transfer and sends bytes to a foreign address. Each time it reads everything back through the bus to confirm the index restarted at 0.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;
   localparam int REG_COUNT = 7;
   localparam int BYTE_W    = 8;

   typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} slv_state_t;
   typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} rx_phase_t;

   // bits that carry a function in each register
   function automatic logic [7:0] reg_mask(input int idx);
      case (idx)
         0:       return 8'hFF;
         1:       return 8'h8F;
         2:       return 8'h7F;
         3:       return 8'hFF;
         4:       return 8'h0F;
         5:       return 8'h13;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reg_reset(input int idx);
      return (idx == 0) ? 8'h00 : reg_mask(idx);
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl   = scl_pipe[STAGES-1];
   assign sda_lvl   = sda_pipe[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import clkgen_cfg_pkg::*;
#(
   parameter int IDX_W = $clog2(REG_COUNT + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [BYTE_W-1:0]           wr_data,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [BYTE_W-1:0]           rd_data,
   output logic [REG_COUNT*BYTE_W-1:0] flat
);
   if ((1 << IDX_W) <= REG_COUNT) begin : g_bad_idx
      $error("cfg_regbank: IDX_W too narrow for REG_COUNT");
   end

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= reg_reset(g);
         else if (wr_en && wr_idx == IDX_W'(g))
            q <= wr_data & reg_mask(g);
      end
      assign flat[g*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_COUNT; i++)
         if (rd_idx == IDX_W'(i)) rd_data = flat[i*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
   import clkgen_cfg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h69,
   parameter int         IDX_W      = $clog2(REG_COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              busy,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx
);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(REG_COUNT);

   slv_state_t        st;
   rx_phase_t         ph;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              rnw;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  idx_next;

   assign idx_next = (idx == IDX_END) ? idx : idx + 1'b1;
   assign rd_idx   = idx;
   assign busy     = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         ph      <= PH_ADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         rnw     <= 1'b0;
         idx     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st     <= S_RX;
            ph     <= PH_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= S_IDLE;
            idx    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               S_RX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (ph == PH_ADDR) begin
                        if (shreg[7:1] == SLAVE_ADDR) begin
                           sda_oe <= 1'b1;
                           rnw    <= shreg[0];
                           ph     <= shreg[0] ? PH_DATA : PH_CMD;
                           st     <= S_RACK;
                        end else begin
                           st <= S_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= S_RACK;
                        case (ph)
                           PH_CMD:  ph <= PH_CNT;
                           PH_CNT:  ph <= PH_DATA;
                           default: begin
                              if (idx != IDX_END) begin
                                 wr_en   <= 1'b1;
                                 wr_idx  <= idx;
                                 wr_data <= shreg;
                                 idx     <= idx_next;
                              end
                           end
                        endcase
                     end
                  end
               end
               S_RACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rnw) begin
                        st     <= S_TX;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        idx    <= idx_next;
                     end else begin
                        st     <= S_RX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               S_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        st     <= S_TACK;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               S_TACK: begin
                  if (scl_rise) begin
                     if (sda_lvl) st <= S_IDLE;
                  end else if (scl_fall) begin
                     st     <= S_TX;
                     bitcnt <= '0;
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[BYTE_W-1];
                     idx    <= idx_next;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
   import clkgen_cfg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR  = 7'h69,
   parameter int         SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        sda_oe,
   output logic        spread_wide,
   output logic        spread_center,
   output logic        spread_en,
   output logic [3:0]  freq_sel,
   output logic        sw_select,
   output logic        tristate_all,
   output logic [3:0]  cpu_en,
   output logic [4:0]  pci_en,
   output logic        pci_free_en,
   output logic [1:0]  agp_en,
   output logic [11:0] sdram_en,
   output logic [1:0]  ref_en
);
   localparam int IDX_W = $clog2(REG_COUNT + 1);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic busy, wr_en;
   logic [IDX_W-1:0]            wr_idx, rd_idx;
   logic [BYTE_W-1:0]           wr_data, rd_data;
   logic [REG_COUNT*BYTE_W-1:0] reg_flat;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2c_cfg_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .sda_oe(sda_oe), .busy(busy), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
   );

   cfg_regbank #(.IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .flat(reg_flat)
   );

   logic [BYTE_W-1:0] r0, r1, r2, r3, r4, r5;
   assign r0 = reg_flat[0*BYTE_W +: BYTE_W];
   assign r1 = reg_flat[1*BYTE_W +: BYTE_W];
   assign r2 = reg_flat[2*BYTE_W +: BYTE_W];
   assign r3 = reg_flat[3*BYTE_W +: BYTE_W];
   assign r4 = reg_flat[4*BYTE_W +: BYTE_W];
   assign r5 = reg_flat[5*BYTE_W +: BYTE_W];

   assign spread_wide   = r0[7];
   assign freq_sel      = {r0[2], r0[6:4]};
   assign sw_select     = r0[3];
   assign spread_en     = r0[1];
   assign tristate_all  = r0[0];
   assign spread_center = r1[7];
   assign cpu_en        = r1[3:0];
   assign pci_en        = r2[4:0];
   assign pci_free_en   = r2[6];
   assign agp_en        = {r5[4], r2[5]};
   assign sdram_en      = {r4[3:0], r3};
   assign ref_en        = r5[1:0];

   logic unused_bits;
   assign unused_bits = ^{r1[6:4], r2[7], r4[7:4], r5[7:5], r5[3:2],
                          reg_flat[REG_COUNT*BYTE_W-1:6*BYTE_W], scl_lvl, busy};
endmodule

// File: rtl/clkgen_cfg_slave_chk.sv
module clkgen_cfg_slave_chk
   import clkgen_cfg_pkg::*;
#(
   parameter int IDX_W = $clog2(REG_COUNT + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        scl_lvl,
   input logic                        sda_oe,
   input logic                        busy,
   input logic                        wr_en,
   input logic [IDX_W-1:0]            wr_idx,
   input logic [REG_COUNT*BYTE_W-1:0] reg_flat
);
   // R8: drive changes only follow a sampled-low SCL
   p_oe_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

   // R2: an idle slave never pulls the line
   p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);

   // R7: registers move only on a write strobe
   p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(reg_flat));

   // R5: no write strobe addresses past the last register
   p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < IDX_W'(REG_COUNT)));

   // R4: writes happen only inside an active transfer
   p_wr_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
endmodule

bind clkgen_cfg_slave clkgen_cfg_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
   .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .reg_flat(reg_flat)
);

// File: tb/clkgen_cfg_slave_test.sv
module clkgen_cfg_slave_test;
   localparam int Q = 10;
   localparam logic [6:0] ADDR = 7'h69;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, sda_line;
   logic spread_wide, spread_center, spread_en, sw_select, tristate_all, pci_free_en;
   logic [3:0] freq_sel, cpu_en;
   logic [4:0] pci_en;
   logic [1:0] agp_en, ref_en;
   logic [11:0] sdram_en;

   int vectors = 0, fails = 0, cycles = 0;
   bit in_flux = 1'b0;
   logic [7:0] model [7];

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   clkgen_cfg_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .spread_wide(spread_wide), .spread_center(spread_center), .spread_en(spread_en),
      .freq_sel(freq_sel), .sw_select(sw_select), .tristate_all(tristate_all),
      .cpu_en(cpu_en), .pci_en(pci_en), .pci_free_en(pci_free_en), .agp_en(agp_en),
      .sdram_en(sdram_en), .ref_en(ref_en)
   );

   function automatic logic [7:0] bmask(input int i);
      case (i)
         0: return 8'hFF; 1: return 8'h8F; 2: return 8'h7F; 3: return 8'hFF;
         4: return 8'h0F; 5: return 8'h13; default: return 8'h00;
      endcase
   endfunction

   function automatic logic [34:0] exp_vec();
      return {model[0][7], model[1][7], model[0][1], model[0][2], model[0][6:4],
              model[0][3], model[0][0], model[1][3:0], model[2][4:0], model[2][6],
              model[5][4], model[2][5], model[4][3:0], model[3], model[5][1:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-clock comparison of all register fields against the model (R1, R4)
   always @(negedge clk) begin
      logic [34:0] dut;
      dut = {spread_wide, spread_center, spread_en, freq_sel, sw_select, tristate_all,
             cpu_en, pci_en, pci_free_en, agp_en, sdram_en, ref_en};
      if (rst_n && !in_flux) chk(dut === exp_vec(), "R4 fields", 64'(dut), 64'(exp_vec()));
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic wq(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b, output logic seen);
      sda_m = b; wq(); scl_m = 1'b1; wq(); seen = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   // returns 1 when the slave acknowledged
   task automatic put_byte(input logic [7:0] b, output logic acked);
      logic seen, a;
      bit clean = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         send_bit(b[i], seen);
         if (seen !== b[i]) clean = 1'b0;
      end
      chk(clean, "R8 line free during master bits", 64'(clean), 64'd1);
      recv_bit(a);
      acked = (a === 1'b0);
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] b);
      logic x, s;
      for (int i = 7; i >= 0; i--) begin recv_bit(x); b[i] = x; end
      send_bit(nack, s);
   endtask

   task automatic addr_phase(input logic [6:0] a, input logic rd, input logic exp_ack, input string req);
      logic ack;
      put_byte({a, rd}, ack);
      chk(ack === exp_ack, req, 64'(ack), 64'(exp_ack));
   endtask

   task automatic write_head();
      logic ack;
      addr_phase(ADDR, 1'b0, 1'b1, "R2 address ack");
      put_byte(8'hA5, ack); chk(ack, "R3 command byte ack", 64'(ack), 64'd1);
      put_byte(8'h3C, ack); chk(ack, "R3 count byte ack", 64'(ack), 64'd1);
   endtask

   task automatic write_data(input int reg_i, input logic [7:0] d);
      logic ack;
      in_flux = 1'b1;
      put_byte(d, ack);
      if (reg_i < 7) begin
         model[reg_i] = d & bmask(reg_i);
         chk(ack, "R4 data ack", 64'(ack), 64'd1);
      end else begin
         chk(ack, "R5 overflow byte ack", 64'(ack), 64'd1);
      end
      in_flux = 1'b0;
   endtask

   task automatic read_check(input int n, input string req);
      logic [7:0] b, e;
      for (int i = 0; i < n; i++) begin
         get_byte(i == n - 1, b);
         e = (i < 7) ? (model[i] & bmask(i)) : 8'h00;
         chk(b === e, req, 64'(b), 64'(e));
      end
   endtask

   initial begin
      for (int i = 0; i < 7; i++) model[i] = (i == 0) ? 8'h00 : bmask(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(spread_center === 1'b1 && sdram_en === 12'hFFF && freq_sel === 4'h0,
          "R1 reset state", 64'({spread_center, sdram_en, freq_sel}), 64'h1FFF0);

      // R1 R6: read defaults, reserved bits and overrun as zero
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(9, "R6 default readback"); bus_stop();

      // R4 R5: full block write plus two extra bytes
      bus_start(); write_head();
      write_data(0, 8'hB7); write_data(1, 8'h05); write_data(2, 8'hAA);
      write_data(3, 8'h3C); write_data(4, 8'hF6); write_data(5, 8'hEE);
      write_data(6, 8'h5A); write_data(7, 8'h00); write_data(8, 8'hFF);
      bus_stop();
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(8, "R6 readback after write"); bus_stop();

      // R2: foreign address ignored
      bus_start(); addr_phase(7'h23, 1'b0, 1'b0, "R2 foreign address nack");
      addr_phase(7'h7F, 1'b1, 1'b0, "R2 no ack after reject"); bus_stop();

      // R7: repeated START restarts the index at register 0
      bus_start(); write_head(); write_data(0, 8'h11); write_data(1, 8'h22);
      bus_start(); write_head(); write_data(0, 8'h40); bus_stop();
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(3, "R7 index reset by repeated start"); bus_stop();

      // R7: write then repeated START into read
      bus_start(); write_head(); write_data(0, 8'h08);
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(2, "R7 read after write restarts at 0"); bus_stop();

      // R6: NACK on first byte ends stream, next read from 0
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(1, "R6 single byte read"); bus_stop();
      bus_start(); addr_phase(ADDR, 1'b1, 1'b1, "R2 read address ack");
      read_check(7, "R6 full read"); bus_stop();
      wq();
      chk(sda_oe === 1'b0, "R8 released when idle", 64'(sda_oe), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule